// File: doc/BRIEF.md
# Ternary Tri-Mode Channel Accumulator

This block sums activation-by-weight products for a group of channels whose weights can only be -1, 0 or +1. Every storage element holds two independent ternary weights, one for each read direction. For each channel, the block receives one 2-bit sensed level code per direction, and a direction select picks which of the two codes applies on a step. The decoded weight picks one of three actions for the channel's activation: skip it, add it or subtract it. On a skip the channel's adder operand is forced to zero and its accumulator is not written.

Activations arrive in one of two forms. In parallel mode a whole two's-complement word comes in on each step. In bit-serial mode one bit comes in per step, least significant bit first, and a shift-and-add term weights each bit by its position. The top bit carries negative weight, and the ternary sign is applied after the bit weighting. A multiway adder tree sums the per-channel accumulators. A step flagged as last latches the tree output into a result register, raises a one-cycle valid pulse and clears all channel accumulators, so the next vector starts from zero.

Top module: `ternary_accum_top`

## Requirements
- R1: Level code decoding is 2'b00 = weight 0, 2'b01 = weight +1, 2'b10 = weight -1. Code 2'b11 is illegal and acts as weight 0.
- R2: With `dirSel` = 0 each channel uses its code from `levelFwd`; with `dirSel` = 1 it uses its code from `levelRev`. Channel c's code sits at bits [2c+1:2c].
- R3: On a valid step where a channel's selected weight is 0, that channel contributes nothing and its accumulator keeps its value.
- R4: In parallel mode (`serialMode` = 0), weight +1 adds the channel's signed activation lane `actData[c*ACT_W +: ACT_W]` and weight -1 subtracts it.
- R5: In serial mode only bit 0 of each lane is used. Bits arrive LSB first, ACT_W steps per element. Bit k has weight 2^k, except bit ACT_W-1, which has weight -2^(ACT_W-1). The weight is then multiplied by the ternary value. The bit position returns to 0 after ACT_W valid steps and after a last step.
- R6: The result equals the sum over all channels of their accumulated contributions, including the contribution of the last step itself.
- R7: One cycle after a valid step with `inLast` high, `resSum` holds the vector's sum, `resValid` is high for exactly that cycle, and every channel accumulator is zero.
- R8: A vector of up to MAX_LEN elements whose channels are all at +1, or all at -1, with full-scale negative activations, gives the exact sum without overflow.
- R9: `codeErr` is high in the cycle after a valid step in which any channel's selected code is 2'b11, and low otherwise. An illegal code in the unselected direction raises no error.
- R10: While `inValid` is low, the accumulators, the bit position, `resSum` and `resValid` do not change. `resSum` changes only after a last step.
- R11: After reset, `resValid` and `codeErr` are 0 and `resSum` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Step qualifier |
| inLast | input | 1 | Final step of a vector (used only with inValid) |
| dirSel | input | 1 | Read direction select: 0 forward, 1 reverse |
| serialMode | input | 1 | 0 parallel words, 1 bit-serial activations |
| actData | input | NUM_CH*ACT_W | Per-channel activation lanes |
| levelFwd | input | 2*NUM_CH | Forward-direction level codes |
| levelRev | input | 2*NUM_CH | Reverse-direction level codes |
| resValid | output | 1 | One-cycle result pulse |
| resSum | output | ACT_W+clog2(MAX_LEN)+clog2(NUM_CH)+1 | Signed vector sum |
| codeErr | output | 1 | Illegal selected code seen on the previous step |

## Verification
All three outputs are registered once. `codeErr` and `resValid` respond to a step one cycle later, and `resSum` carries the new sum in that same cycle. It then holds until the next last step. The bench drives each step just after a rising edge and samples one time unit after the following edge. At that point it compares the error flag, the valid pulse and the sum, or the unchanged previous sum, against a model that accumulates every step's expected contribution. Idle cycles between elements are checked the same way: the bench confirms that no pulse appears and that the result does not move.

// File: rtl/tacc_pkg.sv
package tacc_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b10,
    LVL_BAD  = 2'b11
  } levelCode_e;

  // strobes from control to the datapath
  typedef struct packed {
    logic stepEn;    // a step is applied this cycle
    logic useRev;    // take the reverse-direction code
    logic serial;    // activation is one bit per step
    logic msbStep;   // serial step carrying the sign bit
    logic closeVec;  // latch result and clear accumulators
  } ctrlStrobe_t;

endpackage

// File: rtl/tacc_ctrl.sv
module tacc_ctrl
  import tacc_pkg::*;
#(
  parameter int ACT_W = 8,
  localparam int BIT_W = (ACT_W > 1) ? $clog2(ACT_W) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             dirSel,
  input  logic             serialMode,
  output ctrlStrobe_t      strobe,
  output logic [BIT_W-1:0] bitPos
);

  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(ACT_W - 1);

  logic [BIT_W-1:0] bitCnt;
  logic             atTop;

  assign atTop = (bitCnt == TOP_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (inValid) begin
      if (inLast || !serialMode || atTop) begin
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.stepEn   = inValid;
    strobe.useRev   = dirSel;
    strobe.serial   = serialMode;
    strobe.msbStep  = serialMode && atTop;
    strobe.closeVec = inValid && inLast;
    bitPos          = serialMode ? bitCnt : '0;
  end

endmodule

// File: rtl/tacc_lane.sv
module tacc_lane
  import tacc_pkg::*;
#(
  parameter int ACT_W = 8,
  parameter int ACC_W = 13,
  parameter int BIT_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [BIT_W-1:0]        bitPos,
  input  logic [ACT_W-1:0]        actIn,
  input  logic [1:0]              codeFwd,
  input  logic [1:0]              codeRev,
  output logic signed [ACC_W-1:0] acc,
  output logic signed [ACC_W-1:0] accNext,
  output logic                    codeBad
);

  levelCode_e              selCode;
  logic                    isPos;
  logic                    isNeg;
  logic                    active;
  logic signed [ACC_W-1:0] bitTerm;
  logic signed [ACC_W-1:0] wordTerm;
  logic signed [ACC_W-1:0] magTerm;
  logic signed [ACC_W-1:0] operand;
  logic signed [ACC_W-1:0] sum;

  // comparator outcome: one of three weights, or an illegal level
  always_comb begin
    selCode = levelCode_e'(strobe.useRev ? codeRev : codeFwd);
    isPos   = (selCode == LVL_POS);
    isNeg   = (selCode == LVL_NEG);
    codeBad = (selCode == LVL_BAD);
    active  = strobe.stepEn && (isPos || isNeg);
  end

  // bit weighting first, ternary sign afterwards
  always_comb begin
    bitTerm  = ACC_W'(actIn[0]) << bitPos;
    wordTerm = ACC_W'($signed(actIn));
    if (strobe.serial) begin
      magTerm = strobe.msbStep ? -bitTerm : bitTerm;
    end else begin
      magTerm = wordTerm;
    end
    // operand isolation: a skipped channel presents zero to its adder
    operand = (isPos || isNeg) ? magTerm : '0;
    sum     = isNeg ? (acc - operand) : (acc + operand);
    accNext = active ? sum : acc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobe.closeVec) begin
      acc <= '0;
    end else if (active) begin
      acc <= sum;
    end
  end

endmodule

// File: rtl/tacc_tree.sv
module tacc_tree #(
  parameter int NUM_LEAF = 4,
  parameter int LEAF_W   = 13,
  parameter int SUM_W    = 15
) (
  input  logic [NUM_LEAF*LEAF_W-1:0] leaves,
  output logic signed [SUM_W-1:0]    total
);

  localparam int LEVELS = (NUM_LEAF > 1) ? $clog2(NUM_LEAF) : 0;
  localparam int PAD    = 1 << LEVELS;
  localparam int NODES  = 2 * PAD - 1;

  logic signed [SUM_W-1:0] node [NODES];

  // leaves sit at the bottom of a complete binary tree, spare slots are zero
  for (genvar i = 0; i < PAD; i++) begin : g_leaf
    if (i < NUM_LEAF) begin : g_used
      logic signed [LEAF_W-1:0] leafVal;
      assign leafVal         = leaves[i*LEAF_W +: LEAF_W];
      assign node[PAD-1+i]   = SUM_W'(leafVal);
    end else begin : g_pad
      assign node[PAD-1+i] = '0;
    end
  end

  for (genvar n = 0; n < PAD - 1; n++) begin : g_add
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  assign total = node[0];

endmodule

// File: rtl/tacc_datapath.sv
module tacc_datapath
  import tacc_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ACT_W   = 8,
  parameter int ACC_W   = 13,
  parameter int RES_W   = 15,
  localparam int BIT_W  = (ACT_W > 1) ? $clog2(ACT_W) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [BIT_W-1:0]          bitPos,
  input  logic [NUM_CH*ACT_W-1:0]   actData,
  input  logic [2*NUM_CH-1:0]       levelFwd,
  input  logic [2*NUM_CH-1:0]       levelRev,
  output logic [NUM_CH*ACC_W-1:0]   accFlat,
  output logic                      resValid,
  output logic [RES_W-1:0]          resSum,
  output logic                      codeErr
);

  logic [NUM_CH*ACC_W-1:0] nextFlat;
  logic [NUM_CH-1:0]       laneBad;
  logic signed [RES_W-1:0] treeSum;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic signed [ACC_W-1:0] laneAcc;
    logic signed [ACC_W-1:0] laneNext;

    tacc_lane #(
      .ACT_W (ACT_W),
      .ACC_W (ACC_W),
      .BIT_W (BIT_W)
    ) lane_i (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .bitPos  (bitPos),
      .actIn   (actData[c*ACT_W +: ACT_W]),
      .codeFwd (levelFwd[2*c +: 2]),
      .codeRev (levelRev[2*c +: 2]),
      .acc     (laneAcc),
      .accNext (laneNext),
      .codeBad (laneBad[c])
    );

    assign accFlat[c*ACC_W +: ACC_W]  = laneAcc;
    assign nextFlat[c*ACC_W +: ACC_W] = laneNext;
  end

  // the tree sees the post-step values so the closing step is included
  tacc_tree #(
    .NUM_LEAF (NUM_CH),
    .LEAF_W   (ACC_W),
    .SUM_W    (RES_W)
  ) tree_i (
    .leaves (nextFlat),
    .total  (treeSum)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resSum   <= '0;
      codeErr  <= 1'b0;
    end else begin
      resValid <= strobe.closeVec;
      codeErr  <= strobe.stepEn && (|laneBad);
      if (strobe.closeVec) begin
        resSum <= treeSum;
      end
    end
  end

endmodule

// File: rtl/ternary_accum_top.sv
module ternary_accum_top
  import tacc_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ACT_W   = 8,
  parameter int MAX_LEN = 16,
  localparam int ACC_W  = ACT_W + $clog2(MAX_LEN) + 1,
  localparam int RES_W  = ACC_W + $clog2(NUM_CH),
  localparam int BIT_W  = (ACT_W > 1) ? $clog2(ACT_W) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    inLast,
  input  logic                    dirSel,
  input  logic                    serialMode,
  input  logic [NUM_CH*ACT_W-1:0] actData,
  input  logic [2*NUM_CH-1:0]     levelFwd,
  input  logic [2*NUM_CH-1:0]     levelRev,
  output logic                    resValid,
  output logic [RES_W-1:0]        resSum,
  output logic                    codeErr
);

  ctrlStrobe_t             strobe;
  logic [BIT_W-1:0]        bitPos;
  logic [NUM_CH*ACC_W-1:0] accFlat;

  tacc_ctrl #(
    .ACT_W (ACT_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inLast     (inLast),
    .dirSel     (dirSel),
    .serialMode (serialMode),
    .strobe     (strobe),
    .bitPos     (bitPos)
  );

  tacc_datapath #(
    .NUM_CH (NUM_CH),
    .ACT_W  (ACT_W),
    .ACC_W  (ACC_W),
    .RES_W  (RES_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bitPos   (bitPos),
    .actData  (actData),
    .levelFwd (levelFwd),
    .levelRev (levelRev),
    .accFlat  (accFlat),
    .resValid (resValid),
    .resSum   (resSum),
    .codeErr  (codeErr)
  );

endmodule

// File: rtl/tacc_checker.sv
module tacc_checker #(
  parameter int NUM_CH = 4,
  parameter int ACC_W  = 13,
  parameter int RES_W  = 15
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inLast,
  input logic                    dirSel,
  input logic [2*NUM_CH-1:0]     levelFwd,
  input logic [2*NUM_CH-1:0]     levelRev,
  input logic                    resValid,
  input logic [RES_W-1:0]        resSum,
  input logic                    codeErr,
  input logic [NUM_CH*ACC_W-1:0] accFlat
);

  logic anyBad;
  logic allSkip;
  logic closing;

  always_comb begin
    anyBad  = 1'b0;
    allSkip = 1'b1;
    for (int c = 0; c < NUM_CH; c++) begin
      logic [1:0] sel;
      sel = dirSel ? levelRev[2*c +: 2] : levelFwd[2*c +: 2];
      if (sel == 2'b11) anyBad = 1'b1;
      if (sel == 2'b01 || sel == 2'b10) allSkip = 1'b0;
    end
    closing = inValid && inLast;
  end

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && anyBad) |=> codeErr); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && anyBad) |=> !codeErr); // R9
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    closing |=> resValid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !closing |=> (!resValid && $stable(resSum))); // R10
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    closing |=> (accFlat == '0)); // R7
  AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inLast && allSkip) |=> $stable(accFlat)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(accFlat)); // R10

endmodule

bind ternary_accum_top tacc_checker #(
  .NUM_CH (NUM_CH),
  .ACC_W  (ACC_W),
  .RES_W  (RES_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inLast   (inLast),
  .dirSel   (dirSel),
  .levelFwd (levelFwd),
  .levelRev (levelRev),
  .resValid (resValid),
  .resSum   (resSum),
  .codeErr  (codeErr),
  .accFlat  (accFlat)
);

// File: tb/ternary_accum_top_tb_top.sv
`timescale 1ns/1ps
module ternary_accum_top_tb_top;

  localparam int NUM_CH  = 4;
  localparam int ACT_W   = 8;
  localparam int MAX_LEN = 16;
  localparam int RES_W   = ACT_W + $clog2(MAX_LEN) + 1 + $clog2(NUM_CH);

  logic                    clk = 1'b0;
  logic                    rstN;
  logic                    inValid;
  logic                    inLast;
  logic                    dirSel;
  logic                    serialMode;
  logic [NUM_CH*ACT_W-1:0] actData;
  logic [2*NUM_CH-1:0]     levelFwd;
  logic [2*NUM_CH-1:0]     levelRev;
  logic                    resValid;
  logic [RES_W-1:0]        resSum;
  logic                    codeErr;

  always #4 clk = ~clk;

  ternary_accum_top #(
    .NUM_CH  (NUM_CH),
    .ACT_W   (ACT_W),
    .MAX_LEN (MAX_LEN)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inLast     (inLast),
    .dirSel     (dirSel),
    .serialMode (serialMode),
    .actData    (actData),
    .levelFwd   (levelFwd),
    .levelRev   (levelRev),
    .resValid   (resValid),
    .resSum     (resSum),
    .codeErr    (codeErr)
  );

  int     nChecks = 0;
  int     nErrs   = 0;
  longint expSum  = 0;
  longint lastRes = 0;
  int     bitIdx  = 0;
  bit     finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wOf(input logic [1:0] code);
    if (code == 2'b01) return 1;
    if (code == 2'b10) return -1;
    return 0;
  endfunction

  function automatic logic [1:0] rndCode(input bit allowBad);
    int r;
    r = $urandom % 16;
    if (r < 5) return 2'b01;
    if (r < 10) return 2'b10;
    if (r < 15 || !allowBad) return 2'b00;
    return 2'b11;
  endfunction

  task automatic step(input bit last, input string sumReq);
    longint contrib;
    bit     bad;
    contrib = 0;
    bad     = 0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      logic [1:0] code;
      longint     term;
      code = dirSel ? levelRev[2*ch +: 2] : levelFwd[2*ch +: 2];
      if (code == 2'b11) bad = 1;
      if (serialMode) begin
        term = actData[ch*ACT_W] ? (longint'(1) << bitIdx) : 0;
        if (bitIdx == ACT_W - 1) term = -term;
      end else begin
        term = longint'($signed(actData[ch*ACT_W +: ACT_W]));
      end
      contrib += wOf(code) * term;
    end
    expSum += contrib;
    inValid = 1'b1;
    inLast  = last;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    inLast  = 1'b0;
    if (serialMode) bitIdx = (bitIdx == ACT_W - 1) ? 0 : bitIdx + 1;
    check(codeErr === bad, "R9 error flag", longint'(codeErr), longint'(bad));
    check(resValid === last, "R7 result pulse", longint'(resValid), longint'(last));
    if (last) begin
      check(longint'($signed(resSum)) == expSum, sumReq, longint'($signed(resSum)), expSum);
      lastRes = expSum;
      expSum  = 0;
      bitIdx  = 0;
    end else begin
      check(longint'($signed(resSum)) == lastRes, "R10 result holds mid-vector",
            longint'($signed(resSum)), lastRes);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      check(resValid === 1'b0, "R10 no pulse when idle", longint'(resValid), 0);
      check(longint'($signed(resSum)) == lastRes, "R10 result holds when idle",
            longint'($signed(resSum)), lastRes);
    end
  endtask

  // kind: 0 random, 1 all +1 full-scale negative, 2 all -1 full-scale negative,
  //       3 selected zero, 4 illegal only in unselected direction,
  //       5 forward +1 / reverse -1, 6 fixed decode pattern
  task automatic runVec(input int len, input bit serial, input bit dir, input int kind);
    string req;
    case (kind)
      1, 2:    req = "R8 worst-case sum";
      3:       req = "R3 zero weights skipped";
      4:       req = "R9 unselected illegal code ignored";
      5:       req = "R2 direction select";
      6:       req = "R1 R4 decode add and subtract";
      default: req = "R6 tree sum";
    endcase
    if (serial) req = {"R5 serial ", req};
    serialMode = serial;
    dirSel     = dir;
    for (int e = 0; e < len; e++) begin
      logic [ACT_W-1:0] actVal [NUM_CH];
      for (int ch = 0; ch < NUM_CH; ch++) begin
        logic [1:0] selC;
        logic [1:0] othC;
        actVal[ch] = ACT_W'($urandom);
        othC = rndCode(1);
        case (kind)
          1: begin selC = 2'b01; othC = 2'b01; actVal[ch] = {1'b1, {(ACT_W-1){1'b0}}}; end
          2: begin selC = 2'b10; othC = 2'b10; actVal[ch] = {1'b1, {(ACT_W-1){1'b0}}}; end
          3: begin selC = 2'b00; othC = 2'b01; end
          4: begin selC = rndCode(0); othC = 2'b11; end
          5: begin selC = dir ? 2'b10 : 2'b01; othC = dir ? 2'b01 : 2'b10; end
          6: begin
               selC = 2'(ch);
               othC = 2'b00;
               actVal[ch] = ACT_W'(5 + 2 * ch);
             end
          default: selC = rndCode(1);
        endcase
        levelFwd[2*ch +: 2] = dir ? othC : selC;
        levelRev[2*ch +: 2] = dir ? selC : othC;
      end
      if (serial) begin
        for (int k = 0; k < ACT_W; k++) begin
          for (int ch = 0; ch < NUM_CH; ch++) begin
            actData[ch*ACT_W +: ACT_W] = {ACT_W'($urandom) >> 1, actVal[ch][k]};
          end
          step((e == len - 1) && (k == ACT_W - 1), req);
        end
      end else begin
        for (int ch = 0; ch < NUM_CH; ch++) actData[ch*ACT_W +: ACT_W] = actVal[ch];
        step(e == len - 1, req);
      end
      if (kind == 0 && ($urandom % 4) == 0) idle(1 + $urandom % 3);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrs++;
    $display("FAIL watchdog: actual=running expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'h5EED_0421));
    rstN       = 1'b0;
    inValid    = 1'b0;
    inLast     = 1'b0;
    dirSel     = 1'b0;
    serialMode = 1'b0;
    actData    = '0;
    levelFwd   = '0;
    levelRev   = '0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    check(resValid === 1'b0, "R11 reset valid", longint'(resValid), 0);
    check(codeErr === 1'b0, "R11 reset error flag", longint'(codeErr), 0);
    check(resSum === '0, "R11 reset sum", longint'($signed(resSum)), 0);
    idle(2);

    runVec(1, 0, 0, 6);
    runVec(3, 0, 0, 5);
    runVec(3, 0, 1, 5);
    runVec(MAX_LEN, 0, 0, 1);
    runVec(MAX_LEN, 0, 1, 2);
    runVec(MAX_LEN, 1, 0, 2);
    runVec(MAX_LEN, 1, 1, 1);
    runVec(4, 0, 0, 3);
    runVec(4, 1, 1, 3);
    runVec(4, 0, 1, 4);
    runVec(2, 1, 0, 6);
    for (int v = 0; v < 60; v++) begin
      runVec(1 + int'($urandom % MAX_LEN), bit'($urandom % 2), bit'($urandom % 2), 0);
      if (($urandom % 3) == 0) idle(1);
    end
    idle(2);
    finish();
  end

endmodule